// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the control and status registers for one port of eight general-purpose pins. Software reaches it through a simple 32-bit register bus. It has one write channel and one read address with registered read data. On the pin side it drives an output value vector and an output-enable vector, and it samples the pin levels through a two-flop synchronizer.

Three control registers set up each pin: mode (GPIO ownership), direction, and output value. Each of them can be written in two ways. A plain write at the register's base address replaces all eight bits. A masked write at the register's alias address, a fixed parameterized distance above the plain one, changes only the pins whose select bit is set. Because of this, a driver can update one pin atomically without reading the register first. A pin that is not in GPIO mode never gets its pad driver enabled, whatever its direction bit holds.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the mode, direction and output-value registers read zero, and out_o and oe_o are all zero.
- R2: A plain write at address 0x00 (mode), 0x10 (direction) or 0x20 (output value) loads data bits 7:0 into that register. Data bits 31:8 have no effect.
- R3: A masked write at MASK_OFS+0x00, MASK_OFS+0x10 or MASK_OFS+0x20 updates pin n of the matching register to data bit n only where data bit 8+n is 1. All other pins keep their value, and data bits 31:16 have no effect.
- R4: oe_o[n] is 1 exactly when direction bit n and mode bit n are both 1, so a non-GPIO pin never drives.
- R5: out_o always equals the output-value register.
- R6: The read at address 0x30 returns pin_i after two synchronizer flops. A pin change shows in rd_data_o on the third rising edge after the change and not earlier. Writes to 0x30 or to MASK_OFS+0x30 have no effect.
- R7: rd_data_o is updated one rising edge after rd_addr_i is presented, with bits 31:8 always zero. Masked-alias addresses and unmapped addresses read as zero.
- R8: Writes to any address other than the six control addresses change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Registered read data |
| pin_i | input | NUM_PINS | Raw pin levels |
| out_o | output | NUM_PINS | Output value to pads |
| oe_o | output | NUM_PINS | Output enable to pads |

## Verification
The checker assumes that pin_i changes only in step with the clock, so the two-cycle synchronizer delay is exact. It also assumes that writes arrive at most one per cycle, on a single channel. The bench drives pins and bus signals only on falling edges, which keeps every change one full edge away from sampling. The sweeps walk 256 computed old/select/value combinations per register and all 256 pin patterns, which covers every select-bit combination.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_OE  = 2'd1,
    SEL_OUT = 2'd2,
    SEL_IN  = 2'd3
  } reg_sel_e;

  localparam int NUM_CTL = 3;
  localparam int SLOT_LSB = 4;
  localparam int SLOT_MSB = 5;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int unsigned MASK_OFS = 'h800
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              plain_o,
  output logic              mask_o,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] MOFS = ADDR_W'(MASK_OFS);

  logic              in_mask;
  logic [ADDR_W-1:0] rel;
  logic              aligned;

  always_comb begin
    in_mask = addr_i >= MOFS;
    rel     = in_mask ? addr_i - MOFS : addr_i;
    aligned = (rel[ADDR_W-1:SLOT_MSB+1] == '0) && (rel[SLOT_LSB-1:0] == '0);
    plain_o = !in_mask && aligned;
    mask_o  = in_mask && aligned;
    sel_o   = reg_sel_e'(rel[SLOT_MSB:SLOT_LSB]);
  end
endmodule

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         plain_we_i,
  input  logic         mask_we_i,
  input  logic [2*W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sel_bits;
  logic [W-1:0] val_bits;

  assign sel_bits = data_i[2*W-1:W];
  assign val_bits = data_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (mask_we_i) begin
      q_o <= (q_o & ~sel_bits) | (val_bits & sel_bits);
    end else if (plain_we_i) begin
      q_o <= val_bits;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS = 8,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 12,
  parameter int unsigned MASK_OFS = 'h800
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] oe_o
);
  localparam int MW = 2 * NUM_PINS;

  logic                          wr_plain, wr_mask;
  reg_sel_e                      wr_sel;
  logic                          rd_plain, unused_rd_mask;
  reg_sel_e                      rd_sel;
  logic [NUM_CTL-1:0][NUM_PINS-1:0] ctl_q;
  logic [NUM_PINS-1:0]           cfg_q, oe_q, out_q, in_q;
  logic [DATA_W-1:0]             rd_next;
  logic                          unused_wdata;

  assign unused_wdata = ^wr_data_i[DATA_W-1:MW];

  gpio_addr_decode #(.ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)) u_wr_dec (
    .addr_i (wr_addr_i),
    .plain_o(wr_plain),
    .mask_o (wr_mask),
    .sel_o  (wr_sel)
  );

  gpio_addr_decode #(.ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)) u_rd_dec (
    .addr_i (rd_addr_i),
    .plain_o(rd_plain),
    .mask_o (unused_rd_mask),
    .sel_o  (rd_sel)
  );

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    logic hit;
    assign hit = wr_en_i && (wr_sel == reg_sel_e'(k));
    gpio_masked_reg #(.W(NUM_PINS)) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .plain_we_i(hit && wr_plain),
      .mask_we_i (hit && wr_mask),
      .data_i    (wr_data_i[MW-1:0]),
      .q_o       (ctl_q[k])
    );
  end

  assign cfg_q = ctl_q[SEL_CFG];
  assign oe_q  = ctl_q[SEL_OE];
  assign out_q = ctl_q[SEL_OUT];

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (in_q)
  );

  // pad driver only enabled for pins owned by GPIO
  assign out_o = out_q;
  assign oe_o  = oe_q & cfg_q;

  always_comb begin
    rd_next = '0;
    if (rd_plain) begin
      unique case (rd_sel)
        SEL_CFG: rd_next[NUM_PINS-1:0] = cfg_q;
        SEL_OE:  rd_next[NUM_PINS-1:0] = oe_q;
        SEL_OUT: rd_next[NUM_PINS-1:0] = out_q;
        SEL_IN:  rd_next[NUM_PINS-1:0] = in_q;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_next;
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int          NUM_PINS = 8,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 12,
  parameter int unsigned MASK_OFS = 'h800
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [DATA_W-1:0]   rd_data_o,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] in_q,
  input logic [NUM_PINS-1:0] cfg_q,
  input logic [NUM_PINS-1:0] oe_q,
  input logic [NUM_PINS-1:0] out_o,
  input logic [NUM_PINS-1:0] oe_o
);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_MCFG  = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] A_MOUT  = ADDR_W'(MASK_OFS + 'h20);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  // R7
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:NUM_PINS] == '0);

  // R2
  plain_out_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_OUT) |=> out_o == $past(wr_data_i[NUM_PINS-1:0]));

  // R3
  mask_none_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_MOUT && wr_data_i[2*NUM_PINS-1:NUM_PINS] == '0)
    |=> $stable(out_o));

  // R4
  cfg_clear_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_MCFG && wr_data_i[2*NUM_PINS-1:NUM_PINS] == '1
     && wr_data_i[NUM_PINS-1:0] == '0) |=> oe_o == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_o)));

  // R6
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> in_q == $past(pin_i, 2));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .pin_i    (pin_i),
  .in_q     (in_q),
  .cfg_q    (cfg_q),
  .oe_q     (oe_q),
  .out_o    (out_o),
  .oe_o     (oe_o)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int MO = 'h800;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [N-1:0]  pin_i = '0;
  logic [N-1:0]  out_o, oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [N-1:0] m [3];

  gpio_port_regs #(.NUM_PINS(N), .DATA_W(DW), .ADDR_W(AW), .MASK_OFS(MO)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pin_i(pin_i), .out_o(out_o), .oe_o(oe_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en_i   = 1'b1;
    wr_addr_i = AW'(a);
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    rd_addr_i = AW'(a);
    @(negedge clk_i);
    chk(rd_data_o, exp, tag);
  endtask

  task automatic ports(input string tag);
    chk(DW'(oe_o), DW'(m[1] & m[0]), {tag, " R4 oe_o"});
    chk(DW'(out_o), DW'(m[2]), {tag, " R5 out_o"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    for (int k = 0; k < 3; k++) m[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    ports("R1");
    for (int k = 0; k < 3; k++) rd(k * 16, '0, "R1 reset read");

    // R2/R3 near-exhaustive plain + masked sweep on each control register
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 256; i++) begin
        logic [N-1:0] old, en, val;
        old = N'((i * 37 + k * 11) & 255);
        en  = N'((i * 91 + 7) & 255);
        val = N'((i * 53 + 3) & 255);
        wr(k * 16, 32'h5A5A_5A00 | DW'(old));
        m[k] = old;
        if (i % 16 == 0) rd(k * 16, DW'(old), "R2 plain write");
        wr(MO + k * 16, 32'h3C00_0000 | (DW'(en) << 8) | DW'(val));
        m[k] = (m[k] & ~en) | (val & en);
        rd(k * 16, DW'(m[k]), "R3 masked write");
        ports("R3");
      end
    end

    // R6 input path timing over all pin patterns
    prev = '0;
    rd_addr_i = AW'('h30);
    for (int i = 0; i < 256; i++) begin
      logic [N-1:0] p;
      p = N'((i * 29 + 1) & 255);
      pin_i = p;
      @(negedge clk_i);
      @(negedge clk_i);
      chk(rd_data_o, DW'(prev), "R6 not visible early");
      @(negedge clk_i);
      chk(rd_data_o, DW'(p), "R6 synced input");
      prev = p;
    end

    // R6 input register ignores writes
    wr('h30, 32'hFFFF_FFFF);
    rd('h30, DW'(prev), "R6 plain write to input");
    wr(MO + 'h30, 32'hFFFF_FFFF);
    rd('h30, DW'(prev), "R6 masked write to input");

    // R8 unmapped writes
    wr('h004, 32'hFFFF_FFFF);
    wr('h040, 32'hFFFF_FFFF);
    wr('h100, 32'hFFFF_FFFF);
    wr(MO + 'h04, 32'hFFFF_FFFF);
    wr('h7F0, 32'hFFFF_FFFF);
    for (int k = 0; k < 3; k++) rd(k * 16, DW'(m[k]), "R8 unmapped write");
    ports("R8");

    // R7 unmapped and alias reads
    rd('h040, '0, "R7 unmapped read");
    rd(MO, '0, "R7 alias read");
    rd('h008, '0, "R7 misaligned read");

    // R4 clearing mode drops drive even with direction set
    wr('h10, 32'hFF); m[1] = 8'hFF;
    wr('h00, 32'hFF); m[0] = 8'hFF;
    ports("R4 all owned");
    wr(MO, 32'h0000_0F00); m[0] = 8'hF0;
    ports("R4 low nibble released");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule